// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port. Software reaches it through a simple register bus. A direction register sets each pin to input or output. A data register holds the level that output pins drive, and it shows the sampled level of input pins.

The data register is not reached through one address. It is reached through a whole 1 KB window. Offset bits [9:2] of every access in that window form a per-pin mask. A read returns only the masked bits, and the other bits read as zero. A write changes only the masked bits that are outputs. Software can therefore set or clear a single pin with one store, and it needs no read-modify-write sequence.

An input pin does not drive a level of its own. Its output floats high. External input levels pass through a two-flop synchronizer before they reach the data register.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset the direction is all inputs (0x00), the data register is 0x00, `pin_out` is 0xFF and `bus_rdata` is 0x00.
- R2: A read at any offset below 0x400 returns the data register ANDed with offset bits [9:2]; bit n of the mask is offset bit n+2, and unmasked bits read 0.
- R3: A write at any offset below 0x400 changes only data bits whose mask bit (offset bit n+2) is 1 and whose direction bit is 1; every other data bit keeps its value.
- R4: The direction register sits at offset 0x400; a write loads it from `bus_wdata`, a read returns it, and a 1 bit makes that pin an output.
- R5: `pin_out[n]` equals data bit n when direction bit n is 1, and is 1 (floating high) when direction bit n is 0.
- R6: For input pins, the data bit takes the `pin_in` level through a two-flop synchronizer, within three rising edges of the pin changing; for output pins, `pin_in` has no effect on the data bit.
- R7: Offsets above 0x400 read as 0x00, and writes to them change neither the direction nor the data register.
- R8: `bus_rdata` is loaded on the rising edge that takes a read access, and it holds its value through cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | External pin levels (asynchronous) |
| pin_out | output | 8 | Pin output levels; input pins float high |

## Verification
The hardest case is a pin that changes direction while its data bit holds a value that software never wrote. When an input pin becomes an output, it must drive the level last taken from the pin, not an old written value. The stimulus gets there in three steps. It sets the pins to a known pattern and lets the synchronizer settle. It turns every pin to input so that all bits follow the pins. It then makes the upper nibble outputs and checks `pin_out` and a full-mask read. The stimulus also changes the external levels while pins are outputs, and confirms through reads that the output bits stay put.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;

    // Kind of register access decoded from the bus offset
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_DATA  = 2'd1,
        ACC_DIR   = 2'd2,
        ACC_OTHER = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = async_in;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else begin
                stage_q[g] <= stage_d;
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_mp_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output acc_kind_e         acc_kind,
    output logic              acc_write,
    output logic [NPINS-1:0]  acc_mask
);

    // Data window spans 4 bytes per mask value; direction sits just above it
    localparam int            WIN_BYTES = 1 << (NPINS + 2);
    localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(WIN_BYTES);
    localparam logic [ADDR_W-3:0] DIR_WORD = (ADDR_W-2)'(WIN_BYTES >> 2);

    always_comb begin
        acc_mask  = bus_addr[NPINS+1:2];
        acc_write = bus_sel && bus_wr;
        if (!bus_sel) begin
            acc_kind = ACC_NONE;
        end else if (bus_addr < WIN_END) begin
            acc_kind = ACC_DATA;
        end else if (bus_addr[ADDR_W-1:2] == DIR_WORD) begin
            acc_kind = ACC_DIR;
        end else begin
            acc_kind = ACC_OTHER;
        end
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_mp_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_kind_e        acc_kind,
    input  logic             acc_write,
    input  logic [NPINS-1:0] acc_mask,
    input  logic [NPINS-1:0] wdata,
    input  logic [NPINS-1:0] pin_sync,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] data_q,
    output logic [NPINS-1:0] rdata_q
);

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] data;
        logic [NPINS-1:0] rdata;
    } port_state_t;

    port_state_t cur_q;
    port_state_t nxt_d;
    logic [NPINS-1:0] wr_bits_d;

    always_comb begin
        nxt_d     = cur_q;
        wr_bits_d = acc_mask & cur_q.dir;

        // Input pins track the synchronized pin level; outputs keep their value
        nxt_d.data = (cur_q.data & cur_q.dir) | (pin_sync & ~cur_q.dir);

        if (acc_write) begin
            unique case (acc_kind)
                ACC_DATA: nxt_d.data = (nxt_d.data & ~wr_bits_d) | (wdata & wr_bits_d);
                ACC_DIR:  nxt_d.dir  = wdata;
                default:  ;
            endcase
        end else if (acc_kind != ACC_NONE) begin
            unique case (acc_kind)
                ACC_DATA: nxt_d.rdata = cur_q.data & acc_mask;
                ACC_DIR:  nxt_d.rdata = cur_q.dir;
                default:  nxt_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign dir_q   = cur_q.dir;
    assign data_q  = cur_q.data;
    assign rdata_q = cur_q.rdata;

    // R3: a data write leaves unmasked output bits untouched
    a_r3_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_write && acc_kind == ACC_DATA) |=>
            (((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(acc_mask)) == '0));

    // R6: without a data write, bits that were outputs hold their value
    a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_write && acc_kind == ACC_DATA) |=>
            (((data_q ^ $past(data_q)) & $past(dir_q)) == '0));

    // R6: bits that were inputs take the synchronizer output
    a_r6_in_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_write && acc_kind == ACC_DATA) |=>
            (((data_q ^ $past(pin_sync)) & ~$past(dir_q)) == '0));

    // R4: a direction write loads the written value
    a_r4_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_write && acc_kind == ACC_DIR) |=> (dir_q == $past(wdata)));

    // R7: writes to other offsets change no register
    a_r7_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_write && acc_kind == ACC_OTHER) |=> $stable(dir_q));

    // R8: read data holds when no read is taken
    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_write || acc_kind == ACC_NONE) |=> $stable(rdata_q));

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
    import gpio_mp_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out
);

    acc_kind_e        acc_kind;
    logic             acc_write;
    logic [NPINS-1:0] acc_mask;
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] data_q;

    gpio_pin_sync #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_addr_decode #(
        .NPINS  (NPINS),
        .ADDR_W (ADDR_W)
    ) i_decode (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .acc_kind  (acc_kind),
        .acc_write (acc_write),
        .acc_mask  (acc_mask)
    );

    gpio_port_regs #(
        .NPINS (NPINS)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_kind  (acc_kind),
        .acc_write (acc_write),
        .acc_mask  (acc_mask),
        .wdata     (bus_wdata),
        .pin_sync  (pin_sync),
        .dir_q     (dir_q),
        .data_q    (data_q),
        .rdata_q   (bus_rdata)
    );

    // Outputs drive the data bit; inputs float high
    assign pin_out = (data_q & dir_q) | ~dir_q;

    // R5: a pin that is an input never drives low
    a_r5_input_floats: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pin_out & ~dir_q) == '0));

endmodule

// File: tb/test_gpio_masked_port.sv
`timescale 1ns/1ps
module test_gpio_masked_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } rd_item_t;

    rd_item_t exp_q[$];
    logic rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    gpio_masked_port i_gpio_masked_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] addr, logic [7:0] data);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] addr, logic [7:0] exp, string req);
        rd_item_t it;
        it.exp = exp;
        it.req = req;
        exp_q.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: a read taken at a rising edge is compared at the next falling edge
    always @(posedge clk) rd_seen <= rst_n && bus_sel && !bus_wr;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R8: unexpected read data %02h expected none", bus_rdata);
            end else begin
                rd_item_t it;
                it = exp_q.pop_front();
                check(it.req, bus_rdata, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        idle(3);
        // R1 reset state, before releasing reset
        check("R1", pin_out, 8'hFF);
        check("R1", bus_rdata, 8'h00);
        rst_n = 1'b1;
        idle(1);
        bus_read(12'h3FC, 8'h00, "R1");
        bus_read(12'h400, 8'h00, "R1");
        check("R5", pin_out, 8'hFF);

        // R4 direction: low nibble outputs
        bus_write(12'h400, 8'h0F);
        bus_read(12'h400, 8'h0F, "R4");

        // R5 full-mask writes drive output pins, inputs float
        bus_write(12'h3FC, 8'hFF);
        check("R5", pin_out, 8'hFF);
        bus_write(12'h3FC, 8'hA5);
        check("R5", pin_out, 8'hF5);

        // R3 masked writes: only bit 0 cleared; input bits unaffected
        bus_write(12'h004, 8'h00);
        check("R3", pin_out, 8'hF4);
        bus_write(12'h0C0, 8'hFF);
        bus_write(12'h008, 8'hFF);
        check("R3", pin_out, 8'hF6);
        bus_write(12'h008, 8'h00);
        check("R3", pin_out, 8'hF4);
        bus_read(12'h3FC, 8'h04, "R3");

        // R6 inputs follow pins; R2 masked reads
        pin_in = 8'hB0;
        idle(4);
        bus_read(12'h3FC, 8'hB4, "R6");
        bus_read(12'h204, 8'h80, "R2");
        bus_read(12'h014, 8'h04, "R2");
        bus_read(12'h000, 8'h00, "R2");

        // R6 output bits ignore pins
        pin_in = 8'h0F;
        idle(4);
        bus_read(12'h3FC, 8'h04, "R6");
        check("R6", pin_out, 8'hF4);

        // R7 offsets above direction
        bus_write(12'h404, 8'hFF);
        bus_write(12'h800, 8'hFF);
        bus_read(12'h400, 8'h0F, "R7");
        bus_read(12'h404, 8'h00, "R7");
        bus_read(12'hFFC, 8'h00, "R7");
        bus_read(12'h3FC, 8'h04, "R7");

        // Direction flip: inputs take pins, then upper nibble becomes output
        bus_write(12'h400, 8'h00);
        check("R5", pin_out, 8'hFF);
        idle(1);
        bus_read(12'h3FC, 8'h0F, "R6");
        bus_write(12'h400, 8'hF0);
        check("R5", pin_out, 8'h0F);
        bus_read(12'h3FC, 8'h0F, "R6");
        bus_write(12'h3FC, 8'hA0);
        check("R5", pin_out, 8'hAF);

        // R8 read data holds across writes and idle cycles
        bus_read(12'h400, 8'hF0, "R8");
        held = 8'hF0;
        bus_write(12'h3FC, 8'h50);
        bus_write(12'h400, 8'h3C);
        idle(2);
        check("R8", bus_rdata, held);

        idle(2);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R8: actual %0d pending reads expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule